// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through cache and a slower memory port. Stores from the cache land in a small FIFO and the processor moves on at once. The FIFO drains to memory in arrival order through a single request port that uses a ready/valid handshake.

A read miss does not wait for the FIFO to empty. Its word address is compared against every held entry. On a match, the youngest matching entry answers the read and memory is not touched. With no match, the read takes the memory port ahead of the queued writes, apart from a write the port has already offered and not yet had accepted.

A dirty victim block is handled without extra hardware. The cache pushes the victim's words through the write port, one entry per word, and then issues the miss read. The read reaches memory first, and its answer comes back while the victim words are still queued.

Top module: `wbuf_bypass`

## Requirements
- R1: While reset is asserted, and after it is released, the block holds no entries. It makes no memory request, gives no read response, and keeps `rd_busy` and `wr_stall` low.
- R2: A write is taken on any cycle where `wr_valid` is high and fewer than DEPTH (4) entries are held. While DEPTH entries are held, `wr_valid` raises `wr_stall` in that same cycle and the write is not stored.
- R3: A `rd_req` taken while `rd_busy` is low whose word address equals a held entry makes no memory read. It raises `rd_resp_valid` on the next cycle, carrying the data of the most recently written matching entry.
- R4: A taken `rd_req` with no matching entry raises `rd_busy` from the next cycle. It offers a read (`mem_req_we`=0) to memory. One cycle after `mem_rsp_valid`, it raises `rd_resp_valid` with that data and drops `rd_busy`, so the value returned is the latest value written to that address.
- R5: Writes leave head first with `mem_req_we`=1, one entry per accepted handshake. No write is offered while the buffer is empty or while a read is pending or outstanding, except a write already on offer.
- R6: A pending read is offered ahead of every queued write that is not already on offer. In the cycle a missing read is taken, no new write offer starts.
- R7: A request offered while `mem_req_ready` is low stays offered, with unchanged kind, address and data, until it is accepted.
- R8: When victim words are queued and the miss read follows, the read goes to memory before the queued victim words. Its response is returned while victim words are still held.
- R9: A read is compared only against entries held at the start of its cycle. A write arriving in the same cycle counts as younger and is not forwarded to it.
- R10: A `rd_req` made while `rd_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write store request |
| wr_addr | input | AW | Word address of the store |
| wr_data | input | DW | Store data |
| wr_stall | output | 1 | Store refused, buffer full |
| rd_req | input | 1 | Read miss request |
| rd_addr | input | AW | Word address of the read |
| rd_busy | output | 1 | A read is pending at memory |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Memory word address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |

## Verification
A corrupted head or tail pointer, or a wrong entry count, shows at the memory port on the next offered write as a wrong address or data. It also shows in `wr_stall` in the first cycle the real occupancy crosses full. A wrong youngest-match choice shows one cycle after the read as stale `rd_resp_data`. A stuck read state shows as `rd_busy` disagreeing with the model, or as a write offered while a read is outstanding, within a cycle of the fault.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_PEND = 2'd1,
    RS_WAIT = 2'd2
  } rd_state_t;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] look_addr,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] live, match;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    else return p + PW'(1);
  endfunction

  // per-slot liveness (age below count) and address compare
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [CW:0] age;
    assign age = (PW'(i) >= head_q) ? ((CW+1)'(i) - (CW+1)'(head_q))
                                    : ((CW+1)'(i + DEPTH) - (CW+1)'(head_q));
    assign live[i]  = age < (CW+1)'(cnt_q);
    assign match[i] = live[i] && (addr_q[i] == look_addr);
  end

  // walk from oldest to youngest; the last match wins
  always_comb begin
    logic [PW:0] s;
    s        = '0;
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = {1'b0, head_q} + (PW+1)'(k);
      if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
      if (match[s[PW-1:0]]) begin
        hit      = 1'b1;
        hit_data = data_q[s[PW-1:0]];
      end
    end
  end

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push) tail_d = bump(tail_q);
    if (pop)  head_d = bump(head_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
endmodule

// File: rtl/wbuf_port.sv
module wbuf_port
  import wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  input  logic          buf_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          rd_busy,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  output logic          pop
);
  rd_state_t     st_q, st_d;
  logic          hold_q, hold_d;
  logic          rv_q, rv_d;
  logic [DW-1:0] rdat_q, rdat_d;
  logic [AW-1:0] raddr_q;
  logic          take_rd, rd_miss, offer_wr, offer_rd;

  assign take_rd  = rd_req && (st_q == RS_IDLE);
  assign rd_miss  = take_rd && !hit;
  // an offered write stays until accepted; otherwise reads go first
  assign offer_wr = hold_q || ((st_q == RS_IDLE) && !buf_empty && !rd_miss);
  assign offer_rd = !hold_q && (st_q == RS_PEND);

  assign mem_req_valid = offer_wr || offer_rd;
  assign mem_req_we    = offer_wr;
  assign mem_req_addr  = offer_wr ? head_addr : raddr_q;
  assign mem_req_wdata = offer_wr ? head_data : '0;
  assign pop           = offer_wr && mem_req_ready;

  always_comb begin
    st_d   = st_q;
    rv_d   = 1'b0;
    rdat_d = rdat_q;
    hold_d = offer_wr && !mem_req_ready;
    case (st_q)
      RS_IDLE: begin
        if (take_rd) begin
          if (hit) begin
            rv_d   = 1'b1;
            rdat_d = hit_data;
          end else begin
            st_d = RS_PEND;
          end
        end
      end
      RS_PEND: if (offer_rd && mem_req_ready) st_d = RS_WAIT;
      RS_WAIT: begin
        if (mem_rsp_valid) begin
          rv_d   = 1'b1;
          rdat_d = mem_rsp_data;
          st_d   = RS_IDLE;
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      hold_q <= 1'b0;
      rv_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
      rv_q   <= rv_d;
      rdat_q <= rdat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_miss) raddr_q <= rd_addr;
  end

  assign rd_busy       = (st_q != RS_IDLE);
  assign rd_resp_valid = rv_q;
  assign rd_resp_data  = rdat_q;
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_stall,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_busy,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  logic          full, empty, push, pop, hit;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, hit_data;

  assign wr_stall = wr_valid && full;
  assign push     = wr_valid && !full;

  wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (wr_addr),
    .push_data (wr_data),
    .pop       (pop),
    .look_addr (rd_addr),
    .full      (full),
    .empty     (empty),
    .head_addr (head_addr),
    .head_data (head_data),
    .hit       (hit),
    .hit_data  (hit_data)
  );

  wbuf_port #(.AW(AW), .DW(DW)) u_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_req        (rd_req),
    .rd_addr       (rd_addr),
    .hit           (hit),
    .hit_data      (hit_data),
    .buf_empty     (empty),
    .head_addr     (head_addr),
    .head_data     (head_data),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rd_busy       (rd_busy),
    .rd_resp_valid (rd_resp_valid),
    .rd_resp_data  (rd_resp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .pop           (pop)
  );
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_stall,
  input logic          rd_busy,
  input logic          rd_resp_valid,
  input logic [DW-1:0] rd_resp_data,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid,
  input logic [DW-1:0] mem_rsp_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ_q;
  logic          rdout_q;
  logic          in_ev, out_ev;

  assign in_ev  = wr_valid && !wr_stall;
  assign out_ev = mem_req_valid && mem_req_we && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q   <= '0;
      rdout_q <= 1'b0;
    end else begin
      if (in_ev && !out_ev)      occ_q <= occ_q + CW'(1);
      else if (!in_ev && out_ev) occ_q <= occ_q - CW'(1);
      if (mem_req_valid && !mem_req_we && mem_req_ready) rdout_q <= 1'b1;
      else if (mem_rsp_valid)                            rdout_q <= 1'b0;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!mem_req_valid && !rd_resp_valid && !rd_busy));

  a_r2_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == CW'(DEPTH) && wr_valid) |-> wr_stall);

  a_r2_no_stall_with_room: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q < CW'(DEPTH)) |-> !wr_stall);

  a_r5_no_write_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == '0) |-> !(mem_req_valid && mem_req_we));

  a_r5_no_write_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdout_q |-> !(mem_req_valid && mem_req_we));

  a_r4_resp_follows_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (rdout_q && mem_rsp_valid) |=> (rd_resp_valid && rd_resp_data == $past(mem_rsp_data)));

  a_r7_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) && $stable(mem_req_wdata)));
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .wr_stall      (wr_stall),
  .rd_busy       (rd_busy),
  .rd_resp_valid (rd_resp_valid),
  .rd_resp_data  (rd_resp_data),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data)
);

// File: tb/wbuf_bypass_test.sv
module wbuf_bypass_test;
  localparam int AW = 32, DW = 32, DEPTH = 4, LAT = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, rd_req = 1'b0, mem_req_ready = 1'b0;
  logic          mem_rsp_valid = 1'b0;
  logic [31:0]   wr_addr = '0, wr_data = '0, rd_addr = '0, mem_rsp_data = '0;
  logic          wr_stall, rd_busy, rd_resp_valid, mem_req_valid, mem_req_we;
  logic [31:0]   rd_resp_data, mem_req_addr, mem_req_wdata;

  wbuf_bypass #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_busy(rd_busy),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] a; logic [31:0] d; } ent_t;
  ent_t        q[$];
  int          rstate = 0;
  logic [31:0] raddr = '0;
  bit          hold = 0, m_rv = 0;
  logic [31:0] m_rd = '0, exp_rd = '0;
  logic [31:0] mem  [logic [31:0]];
  logic [31:0] arch [logic [31:0]];
  int          rsp_cnt = 0;
  logic [31:0] rsp_addr = '0;
  bit          e_hit, e_offw, e_offr, e_stall;
  logic [31:0] e_fwd;
  bit          victim_phase = 0, same_cycle_phase = 0;

  function automatic logic [31:0] dflt(logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] mrd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return dflt(a);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    bit full0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mrd(rsp_addr);
      end
    end
    #1;
    e_stall = wr_valid && (q.size() == DEPTH);
    e_hit = 0; e_fwd = '0;
    if (rd_req && rstate == 0)
      foreach (q[i]) if (q[i].a == rd_addr) begin e_hit = 1; e_fwd = q[i].d; end
    e_offw = hold || (rstate == 0 && q.size() > 0 && !(rd_req && !e_hit));
    e_offr = !hold && rstate == 1;

    chk("R2", "wr_stall", 32'(wr_stall), 32'(e_stall));
    chk("R10", "rd_busy", 32'(rd_busy), 32'(rstate != 0));
    chk("R3", "rd_resp_valid", 32'(rd_resp_valid), 32'(m_rv));
    if (m_rv) begin
      chk("R3", "rd_resp_data model", rd_resp_data, m_rd);
      chk("R4", "rd_resp_data latest value", rd_resp_data, exp_rd);
      if (victim_phase) chk("R8", "victim words still held at response", 32'(q.size() > 0), 32'd1);
      if (same_cycle_phase) chk("R9", "same-cycle write not forwarded", rd_resp_data, dflt(32'h20));
    end
    chk("R6", "mem_req_valid", 32'(mem_req_valid), 32'(e_offw || e_offr));
    if (e_offw || e_offr) begin
      chk(hold ? "R7" : "R5", "mem_req_we", 32'(mem_req_we), 32'(e_offw));
      chk(hold ? "R7" : "R6", "mem_req_addr", mem_req_addr, e_offw ? q[0].a : raddr);
      if (e_offw) chk("R5", "mem_req_wdata", mem_req_wdata, q[0].d);
    end

    @(posedge clk);
    m_rv  = 0;
    full0 = (q.size() == DEPTH);
    if (e_offw && mem_req_ready) begin
      mem[q[0].a] = q[0].d;
      void'(q.pop_front());
    end
    hold = e_offw && !mem_req_ready;
    if (rstate == 0) begin
      if (rd_req) begin
        exp_rd = arch.exists(rd_addr) ? arch[rd_addr] : dflt(rd_addr);
        if (e_hit) begin m_rv = 1; m_rd = e_fwd; end
        else begin rstate = 1; raddr = rd_addr; end
      end
    end else if (rstate == 1) begin
      if (e_offr && mem_req_ready) begin rstate = 2; rsp_cnt = LAT; rsp_addr = raddr; end
    end else if (mem_rsp_valid) begin
      m_rv = 1; m_rd = mem_rsp_data; rstate = 0;
    end
    if (wr_valid && !full0) begin
      q.push_back('{wr_addr, wr_data});
      arch[wr_addr] = wr_data;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    rd_req   = 1'b0;
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic rd(logic [31:0] a);
    rd_req = 1'b1; rd_addr = a;
  endtask

  task automatic drain();
    mem_req_ready = 1'b1;
    for (int n = 0; n < 100; n++) begin
      if (rstate == 0 && q.size() == 0 && rsp_cnt == 0 && !m_rv) break;
      tick();
    end
  endtask

  initial begin
    @(negedge clk);
    repeat (3) tick();
    // R1: quiet outputs during and after reset
    chk("R1", "mem_req_valid in reset", 32'(mem_req_valid), 0);
    chk("R1", "rd_busy in reset", 32'(rd_busy), 0);
    rst_n = 1'b1;
    tick();
    chk("R1", "rd_resp_valid after reset", 32'(rd_resp_valid), 0);
    chk("R1", "wr_stall after reset", 32'(wr_stall), 0);

    // R2: fill with a stalled memory, fifth write refused
    mem_req_ready = 1'b0;
    wr(32'h10, 32'hA1); tick();
    wr(32'h11, 32'hA2); tick();
    wr(32'h10, 32'hA3); tick();
    wr(32'h12, 32'hA4); tick();
    wr(32'h13, 32'hA5); tick();
    // R3: youngest match forwarded, no memory read
    rd(32'h10); tick();
    rd(32'h12); tick();
    // R4/R6: miss waits only for the write already on offer
    rd(32'h99); tick();
    rd(32'h10); tick();   // R10: ignored while busy
    tick();
    drain();
    chk("R2", "stalled write reached memory", 32'(mem.exists(32'h13)), 0);

    // R4: miss after drain returns latest written value
    rd(32'h10); tick();
    drain();

    // R9/R7: same-cycle write is younger; read offer held while not ready
    same_cycle_phase = 1;
    mem_req_ready = 1'b0;
    wr(32'h20, 32'hB1); rd(32'h20); tick();
    tick(); tick();
    drain();
    same_cycle_phase = 0;

    // R8: victim words queued, then the miss read
    victim_phase = 1;
    mem_req_ready = 1'b0;
    for (int w = 0; w < 4; w++) begin wr(32'h80 + 32'(w), 32'hC0 + 32'(w)); tick(); end
    rd(32'h90); tick();
    tick();
    drain();
    victim_phase = 0;

    // mixed traffic
    for (int c = 0; c < 400; c++) begin
      mem_req_ready = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 2) == 0) wr(32'h40 + 32'($urandom_range(0, 7)), $urandom);
      if ($urandom_range(0, 3) == 0) rd(32'h40 + 32'($urandom_range(0, 7)));
      tick();
    end
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule